// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Byte

This block performs the increment, add and add-with-carry operations of an 8-bit accumulator machine. It also builds the complete 8-bit status byte in the same pass, so the core never needs a separate step to fix up the flags.

A caller presents an operation code, two operands and the current status byte, and raises a strobe for one cycle. On the next clock edge the block registers the 8-bit result and the new status byte, and it marks them valid for exactly one cycle. Strobes may arrive back to back. Add-with-carry takes its carry-in from bit 0 of the status byte the caller supplies. To chain operations, the caller feeds the previous status byte back in.

A two-state controller handles sequencing. The states are `ST_IDLE` (no fresh result) and `ST_EMIT` (a fresh result is on the outputs):

- Transition `take`: to `ST_EMIT` on an accepted strobe, from either state.
- Transition `drop`: to `ST_IDLE` in any cycle without an accepted strobe.

Top module: `acc_arith_unit`

## Requirements
- R1: While reset is asserted (active low), and in the first cycle after it, `out_valid`, `result` and `flags_out` are all zero.
- R2: A strobe with operation code 00, 01 or 10 produces `out_valid` high in the cycle after the strobe edge. `out_valid` is high for exactly one cycle per accepted strobe and is low otherwise.
- R3: Operation code 00 (increment) gives `opa`+1 modulo 256, and `opb` is ignored. Code 01 (add) gives `opa`+`opb` modulo 256. Code 10 (add-with-carry) gives `opa`+`opb`+`flags_in[0]` modulo 256.
- R4: A strobe with operation code 11 is rejected. `out_valid` stays low, and `result` and `flags_out` keep their values.
- R5: In `flags_out`, bit 7 (sign) equals result bit 7, bit 5 equals result bit 5, bit 3 equals result bit 3, and bit 1 (subtract) is 0 for all three operations.
- R6: Bit 6 (zero) is 1 exactly when all eight result bits are 0.
- R7: Bit 4 (half-carry) depends on the operation. For increment, it is 1 exactly when result bits 3..0 are all zero. For add and add-with-carry, it is 1 when the sum of the operands' low nibbles, plus the carry-in for add-with-carry, exceeds 15.
- R8: Bit 2 (overflow) depends on the operation. For increment, it is 1 exactly when result bits 6..0 are zero and bit 7 is one (operand 7Fh). For add and add-with-carry, it is 1 when the operands have the same sign and the result's sign differs from it.
- R9: Bit 0 (carry) is the carry out of bit 7 for add and add-with-carry. For increment, it is a copy of `flags_in[0]`.
- R10: While `out_valid` is low, `result` and `flags_out` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | Operation code: 00 increment, 01 add, 10 add-with-carry, 11 rejected |
| opa | input | 8 | First operand (the accumulator) |
| opb | input | 8 | Second operand |
| flags_in | input | 8 | Current status byte; bit 0 is the incoming carry |
| out_valid | output | 1 | Result and status byte are fresh this cycle |
| result | output | 8 | Registered result |
| flags_out | output | 8 | Registered status byte |

## Verification
Every result and status byte is due one clock after the strobe edge. The bench therefore drives inputs on the falling edge and samples the outputs 1 ns after the next rising edge. At that point the expected entry the driver queued just before the edge is compared. In each sample cycle with `out_valid` low, the bench checks that the queue is empty and that both outputs held their values. This is how rejected codes and idle cycles are verified.

// File: rtl/acc_arith_pkg.sv
package acc_arith_pkg;

    typedef enum logic [1:0] {
        OP_INC  = 2'b00,
        OP_ADD  = 2'b01,
        OP_ADC  = 2'b10,
        OP_RSVD = 2'b11
    } arith_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;

    localparam int FLAG_W  = 8;
    localparam int FLG_C   = 0;
    localparam int FLG_N   = 1;
    localparam int FLG_PV  = 2;
    localparam int FLG_R3  = 3;
    localparam int FLG_H   = 4;
    localparam int FLG_R5  = 5;
    localparam int FLG_Z   = 6;
    localparam int FLG_S   = 7;

endpackage

// File: rtl/acc_ripple_add.sv
module acc_ripple_add #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              c_half,
    output logic              c_into_msb,
    output logic              c_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    assign c_half     = carry[HALF_W];
    assign c_into_msb = carry[DATA_W-1];
    assign c_out      = carry[DATA_W];

endmodule

// File: rtl/acc_flag_gen.sv
module acc_flag_gen
    import acc_arith_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  arith_op_e            op,
    input  logic [DATA_W-1:0]    sum,
    input  logic                 c_half,
    input  logic                 c_into_msb,
    input  logic                 c_out,
    input  logic                 carry_keep,
    output logic [FLAG_W-1:0]    flags
);
    localparam int HALF_W = DATA_W / 2;

    logic half_f;
    logic ovf_f;
    logic carry_f;

    always_comb begin
        unique case (op)
            OP_INC: begin
                half_f  = (sum[HALF_W-1:0] == '0);
                ovf_f   = sum[DATA_W-1] & (sum[DATA_W-2:0] == '0);
                carry_f = carry_keep;
            end
            OP_ADD, OP_ADC: begin
                half_f  = c_half;
                ovf_f   = c_into_msb ^ c_out;
                carry_f = c_out;
            end
            OP_RSVD: begin
                half_f  = 1'b0;
                ovf_f   = 1'b0;
                carry_f = carry_keep;
            end
        endcase
    end

    always_comb begin
        flags         = '0;
        flags[FLG_S]  = sum[DATA_W-1];
        flags[FLG_Z]  = (sum == '0);
        flags[FLG_R5] = sum[5];
        flags[FLG_H]  = half_f;
        flags[FLG_R3] = sum[3];
        flags[FLG_PV] = ovf_f;
        flags[FLG_N]  = 1'b0;
        flags[FLG_C]  = carry_f;
    end

endmodule

// File: rtl/acc_emit_ctrl.sv
module acc_emit_ctrl
    import acc_arith_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  arith_op_e op,
    output logic      accept,
    output logic      emit
);
    emit_state_e state_q;
    emit_state_e state_d;

    assign accept = in_valid && (op != OP_RSVD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = accept ? ST_EMIT : ST_IDLE;
        endcase
    end

    assign emit = (state_q == ST_EMIT);

endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
    import acc_arith_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags_out
);
    arith_op_e         op_e;
    logic [DATA_W-1:0] addend;
    logic              cin;
    logic [DATA_W-1:0] sum;
    logic              c_half;
    logic              c_into_msb;
    logic              c_out;
    logic [FLAG_W-1:0] flags_d;
    logic              accept;

    assign op_e   = arith_op_e'(op);
    assign addend = (op_e == OP_INC) ? DATA_W'(1) : opb;
    assign cin    = (op_e == OP_ADC) ? flags_in[FLG_C] : 1'b0;

    acc_ripple_add #(.DATA_W(DATA_W)) add_i (
        .a          (opa),
        .b          (addend),
        .cin        (cin),
        .sum        (sum),
        .c_half     (c_half),
        .c_into_msb (c_into_msb),
        .c_out      (c_out)
    );

    acc_flag_gen #(.DATA_W(DATA_W)) flag_i (
        .op         (op_e),
        .sum        (sum),
        .c_half     (c_half),
        .c_into_msb (c_into_msb),
        .c_out      (c_out),
        .carry_keep (flags_in[FLG_C]),
        .flags      (flags_d)
    );

    acc_emit_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op       (op_e),
        .accept   (accept),
        .emit     (out_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            flags_out <= '0;
        end else if (accept) begin
            result    <= sum;
            flags_out <= flags_d;
        end
    end

endmodule

// File: rtl/acc_arith_chk.sv
module acc_arith_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] op,
    input logic [7:0] opa,
    input logic [7:0] opb,
    input logic [7:0] flags_in,
    input logic       out_valid,
    input logic [7:0] result,
    input logic [7:0] flags_out
);
    assert_accept_emits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 2'b11) |=> out_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_rsvd_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11) |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(result) && $stable(flags_out)));

    assert_add_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 2'b01) |-> (result == 8'($past(opa) + $past(opb))));

    assert_copy_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags_out[7] == result[7] && flags_out[5] == result[5] &&
                       flags_out[3] == result[3] && !flags_out[1]));

    assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags_out[6] == (result == 8'h00)));

    assert_inc_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 2'b00) |-> (flags_out[4] == (result[3:0] == 4'h0)));

    assert_inc_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 2'b00) |-> (flags_out[2] == (result == 8'h80)));

    assert_inc_keeps_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 2'b00) |-> (flags_out[0] == $past(flags_in[0])));

endmodule

bind acc_arith_unit acc_arith_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out)
);

// File: tb/acc_arith_unit_tb_top.sv
`timescale 1ns/1ps
module acc_arith_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] opa = 8'h00;
    logic [7:0] opb = 8'h00;
    logic [7:0] flags_in = 8'h00;
    logic       out_valid;
    logic [7:0] result;
    logic [7:0] flags_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] exp_q[$];
    logic [7:0]  last_res = 8'h00;
    logic [7:0]  last_flg = 8'h00;
    logic [7:0]  chain_flg = 8'h00;

    always #2.5 clk = ~clk;

    acc_arith_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .opa       (opa),
        .opb       (opb),
        .flags_in  (flags_in),
        .out_valid (out_valid),
        .result    (result),
        .flags_out (flags_out)
    );

    // Bit layout: 7 sign, 6 zero, 5 copy, 4 half, 3 copy, 2 ovf, 1 sub, 0 carry.
    function automatic logic [15:0] model(input logic [1:0] o, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] f);
        logic [8:0] s9;
        logic [7:0] r;
        logic       h, v, c, ci;
        if (o == 2'b00) begin
            r = a + 8'd1;
            h = (r[3:0] == 4'h0);
            v = (r == 8'h80);
            c = f[0];
        end else begin
            ci = (o == 2'b10) ? f[0] : 1'b0;
            s9 = {1'b0, a} + {1'b0, b} + {8'h00, ci};
            r  = s9[7:0];
            h  = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'h0, ci}) > 5'd15;
            v  = (a[7] == b[7]) && (r[7] != a[7]);
            c  = s9[8];
        end
        return {r, r[7], (r == 8'h00), r[5], h, r[3], v, 1'b0, c};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] o, input logic [7:0] a,
                        input logic [7:0] b, input logic [7:0] f);
        logic [15:0] e;
        @(negedge clk);
        in_valid = 1'b1;
        op = o; opa = a; opb = b; flags_in = f;
        if (o != 2'b11) begin
            e = model(o, a, b, f);
            exp_q.push_back(e);
            chain_flg = e[7:0];
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected out_valid", 8'h01, 8'h00);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk("R3 result", result, e[15:8]);
                    chk("R5 sign/copy/sub bits", flags_out & 8'hAA, e[7:0] & 8'hAA);
                    chk("R6 zero", flags_out & 8'h40, e[7:0] & 8'h40);
                    chk("R7 half-carry", flags_out & 8'h10, e[7:0] & 8'h10);
                    chk("R8 overflow", flags_out & 8'h04, e[7:0] & 8'h04);
                    chk("R9 carry", flags_out & 8'h01, e[7:0] & 8'h01);
                end
                last_res = result;
                last_flg = flags_out;
            end else begin
                chk("R2 missing out_valid", 8'(exp_q.size()), 8'h00);
                chk("R10 result hold", result, last_res);
                chk("R10 flags hold", flags_out, last_flg);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 out_valid in reset", {7'h0, out_valid}, 8'h00);
        chk("R1 result in reset", result, 8'h00);
        chk("R1 flags in reset", flags_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 out_valid after reset", {7'h0, out_valid}, 8'h00);
        chk("R1 result after reset", result, 8'h00);

        // Increment corners (R3, R7, R8, R9); B must be ignored.
        send(2'b00, 8'h7F, 8'hA5, 8'h00); idle(1);
        send(2'b00, 8'hFF, 8'h33, 8'h01); idle(1);
        send(2'b00, 8'hFF, 8'h00, 8'h00); idle(2);
        send(2'b00, 8'h0F, 8'hFF, 8'h01); idle(1);
        send(2'b00, 8'h27, 8'h00, 8'h00); idle(1);

        // Add then add-with-carry chain: 05+FF carries, ADC 01 yields 06 (R9, R3).
        send(2'b01, 8'h05, 8'hFF, 8'h00);
        send(2'b10, 8'h04, 8'h01, chain_flg);
        idle(1);
        chk("R3 chained ADC model", model(2'b10, 8'h04, 8'h01, model(2'b01, 8'h05, 8'hFF, 8'h00)) >> 8, 8'h06);

        // Signed overflow and zero with carry (R8, R6).
        send(2'b01, 8'h7F, 8'h01, 8'h00);
        send(2'b01, 8'h80, 8'h80, 8'h00);
        send(2'b10, 8'h0E, 8'h01, 8'h01);
        send(2'b10, 8'h0E, 8'h01, 8'h00);
        idle(1);

        // Rejected code (R4)
        send(2'b11, 8'h12, 8'h34, 8'h01);
        idle(1);
        chk("R4 rejected code, no out_valid", {7'h0, out_valid}, 8'h00);
        chk("R4 rejected code, result held", result, last_res);
        idle(2);

        // Back-to-back sweep with chained status (R2, R3..R9)
        for (int i = 0; i < 300; i++) begin
            send(2'(i % 3), 8'(i * 37 + 11), 8'(i * 91 + 5), chain_flg);
            if (i % 17 == 0) idle(1);
        end
        idle(3);
        chk("R2 queue drained", 8'(exp_q.size()), 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule